// File: doc/BRIEF.md
# Descriptor Table Register Loader

This block loads and reads back the two segment-table shadow registers of a protected-mode core: the local descriptor table register and the task register. A load takes a 16-bit selector, fetches the eight-byte descriptor it names from the global table in memory, and assembles its scattered base and limit pieces into a shadow register. The register holds the selector, a 32-bit base, a 32-bit byte-granular limit and the access byte. A task-register load also marks the descriptor busy in memory before it commits. A store returns the selector currently held.

Commands enter on a valid/ready handshake. `cmd_ready` is high only while the block is idle. The command fields are sampled in the cycle where `cmd_valid` and `cmd_ready` are both high. A command offered while the block is busy waits, and the offerer must hold it stable. Memory requests leave on a second valid/ready handshake. A request stays stable until `mem_req_ready` accepts it. Each accepted request returns exactly one response, which may arrive any number of cycles later. Responses cannot be back-pressured. Each command ends with a one-cycle `done` and a status code.

Top module: `seg_table_loader`

## Requirements
- R1: Operation code: 0 reads the local selector, 1 reads the task selector, 2 loads the local register, 3 loads the task register. A load (code 2 or 3) issued while `prot_en` is 1 and either `cur_cpl` is nonzero or `virt_mode` is 1 ends with status 1 (privilege fault). It issues no memory request and changes no shadow register.
- R2: The descriptor address is `gtab_base` plus the selector with its three low bits cleared. Selector bits 2..0 do not affect the lookup, but the full selector is stored.
- R3: The loaded limit is the little-endian word at offset 0, plus bits 3..0 of the byte at offset 6 placed at bits 19..16.
- R4: The loaded base takes bits 15..0 from the little-endian word at offset 2, bits 23..16 from the byte at offset 4, and bits 31..24 from the byte at offset 7.
- R5: The access byte is the byte at offset 5. When bit 7 of the byte at offset 6 is 1, the stored limit is the assembled limit shifted left by 12 with the low 12 bits set to one.
- R6: A task-register load writes the access byte with bit 1 set back to offset 5 as a byte write. This write is the last memory request. The shadow access byte also has bit 1 set, and the register commits only after the write completes without a fault.
- R7: Codes 0 and 1 return the held selector on `result_sel` with status 0. They perform no privilege check and issue no memory request.
- R8: A fault response on any read or on the write-back ends the command with status 2 and leaves both shadow registers unchanged.
- R9: Every accepted command produces exactly one `done` pulse one cycle long. `cmd_ready` is low from acceptance until after `done`. A successful load has status 0.
- R10: After reset, both shadow registers hold selector 0, base 0, limit 0 and access 0. `done` is 0 and `cmd_ready` is 1.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, direction and size stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and accepting |
| cmd_op | input | 2 | Operation code (see R1) |
| cmd_sel | input | 16 | Selector for loads |
| cur_cpl | input | 2 | Current privilege level |
| virt_mode | input | 1 | Virtual-8086 mode active |
| prot_en | input | 1 | Protection enabled |
| gtab_base | input | ADDR_W | Global table base address |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 privilege fault, 2 memory fault |
| result_sel | output | 16 | Selector returned by a read operation |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_word | output | 1 | 1 word access, 0 byte access |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 16 | Write data (byte in bits 7..0) |
| mem_rsp_valid | input | 1 | Response for the oldest accepted request |
| mem_rsp_fault | input | 1 | Response carries a fault |
| mem_rsp_data | input | 16 | Read data, little-endian word or byte in bits 7..0 |
| ldt_sel | output | 16 | Local register selector |
| ldt_base | output | 32 | Local register base |
| ldt_limit | output | 32 | Local register limit |
| ldt_access | output | 8 | Local register access byte |
| tr_sel | output | 16 | Task register selector |
| tr_base | output | 32 | Task register base |
| tr_limit | output | 32 | Task register limit |
| tr_access | output | 8 | Task register access byte |

## Verification
The bench uses selectors with the table-indicator and privilege bits set. A design that kept those bits in the address would fetch a misaligned descriptor and get every field wrong. It pairs one descriptor that has the granularity bit with one that has only other flag bits set, which exposes a missing or misplaced scaling. It injects a fault on a middle read and another on the busy write-back. A design that commits early, or writes memory despite the fault, would leave a changed shadow register or a busy-marked byte behind. It sends read operations at nonzero privilege in virtual mode and loads with protection turned off. This catches a privilege check that is applied to the wrong operations or ignores the protection bit. It stalls memory requests at random, so a request that changes while stalled would corrupt the fetched data.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  typedef enum logic [1:0] {
    OP_READ_LOCAL = 2'd0,
    OP_READ_TASK  = 2'd1,
    OP_LOAD_LOCAL = 2'd2,
    OP_LOAD_TASK  = 2'd3
  } dtr_op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_PRIV  = 2'd1,
    ST_MEMER = 2'd2
  } dtr_status_e;

  localparam int SEL_W      = 16;
  localparam int REG_W      = 32;
  localparam int STEP_W     = 3;
  localparam logic [STEP_W-1:0] LAST_READ  = 3'd5;
  localparam logic [STEP_W-1:0] WRITE_STEP = 3'd6;

  // raw descriptor pieces as captured from memory
  typedef struct packed {
    logic [15:0] lim_lo;
    logic [15:0] base_lo;
    logic [7:0]  base_mid;
    logic [7:0]  acc;
    logic [7:0]  attr;
    logic [7:0]  base_hi;
  } desc_raw_t;

  // byte offset inside the descriptor for each fetch step
  function automatic logic [2:0] step_offset(input logic [STEP_W-1:0] s);
    case (s)
      3'd0:    step_offset = 3'd0;
      3'd1:    step_offset = 3'd2;
      3'd2:    step_offset = 3'd4;
      3'd3:    step_offset = 3'd5;
      3'd4:    step_offset = 3'd6;
      3'd5:    step_offset = 3'd7;
      default: step_offset = 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/stl_unpack.sv
module stl_unpack
  import dtr_pkg::*;
#(
  parameter int PAGE_SHIFT = 12
) (
  input  desc_raw_t        raw,
  input  logic             is_task,
  output logic [REG_W-1:0] base,
  output logic [REG_W-1:0] limit,
  output logic [7:0]       access,
  output logic [7:0]       busy_byte
);
  localparam int RAW_LIM_W = 20;
  localparam logic [REG_W-1:0] LOW_FILL = REG_W'((64'd1 << PAGE_SHIFT) - 64'd1);

  logic [RAW_LIM_W-1:0] lim_raw;
  logic [REG_W-1:0]     lim_ext;
  logic                 gran;

  assign lim_raw   = {raw.attr[3:0], raw.lim_lo};
  assign lim_ext   = REG_W'(lim_raw);
  assign gran      = raw.attr[7];
  assign base      = {raw.base_hi, raw.base_mid, raw.base_lo};
  assign limit     = gran ? ((lim_ext << PAGE_SHIFT) | LOW_FILL) : lim_ext;
  assign busy_byte = raw.acc | 8'h02;
  assign access    = is_task ? busy_byte : raw.acc;

endmodule

// File: rtl/stl_shadow.sv
module stl_shadow
  import dtr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [SEL_W-1:0] sel_in,
  input  logic [REG_W-1:0] base_in,
  input  logic [REG_W-1:0] limit_in,
  input  logic [7:0]       access_in,
  output logic [SEL_W-1:0] sel_q,
  output logic [REG_W-1:0] base_q,
  output logic [REG_W-1:0] limit_q,
  output logic [7:0]       access_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      base_q   <= '0;
      limit_q  <= '0;
      access_q <= '0;
    end else if (commit) begin
      sel_q    <= sel_in;
      base_q   <= base_in;
      limit_q  <= limit_in;
      access_q <= access_in;
    end
  end

  // R8: contents move only on a commit
  assert_hold_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(sel_q) && $stable(base_q) && $stable(limit_q) && $stable(access_q)));

endmodule

// File: rtl/stl_sequencer.sv
module stl_sequencer
  import dtr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic [1:0]        cur_cpl,
  input  logic              virt_mode,
  input  logic              prot_en,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [SEL_W-1:0]  held_local_sel,
  input  logic [SEL_W-1:0]  held_task_sel,
  input  logic [7:0]        busy_byte,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_fault,
  input  logic [15:0]       mem_rsp_data,
  output desc_raw_t         raw,
  output logic              is_task,
  output logic [SEL_W-1:0]  load_sel,
  output logic              commit_local,
  output logic              commit_task,
  output logic              done,
  output logic [1:0]        done_status,
  output logic [SEL_W-1:0]  result_sel
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} seq_state_e;

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  dtr_op_e           op_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] dbase_q;
  desc_raw_t         raw_q;
  dtr_status_e       status_q;
  logic [SEL_W-1:0]  result_q;

  logic cmd_fire;
  logic priv_bad;
  logic last_step;
  logic [ADDR_W-1:0] sel_offset;

  assign cmd_ready  = (state == S_IDLE);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign priv_bad   = prot_en && ((cur_cpl != 2'd0) || virt_mode);
  assign sel_offset = ADDR_W'({cmd_sel[SEL_W-1:3], 3'b000});
  assign last_step  = (step == WRITE_STEP) ||
                      ((step == LAST_READ) && (op_q != OP_LOAD_TASK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step     <= '0;
      op_q     <= OP_READ_LOCAL;
      sel_q    <= '0;
      dbase_q  <= '0;
      raw_q    <= '0;
      status_q <= ST_OK;
      result_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cmd_fire) begin
            op_q     <= dtr_op_e'(cmd_op);
            sel_q    <= cmd_sel;
            dbase_q  <= gtab_base + sel_offset;
            step     <= '0;
            result_q <= '0;
            status_q <= ST_OK;
            if (!cmd_op[1]) begin
              result_q <= cmd_op[0] ? held_task_sel : held_local_sel;
              state    <= S_FIN;
            end else if (priv_bad) begin
              status_q <= ST_PRIV;
              state    <= S_FIN;
            end else begin
              state    <= S_ISSUE;
            end
          end
        end
        S_ISSUE: begin
          if (mem_req_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_fault) begin
              status_q <= ST_MEMER;
              state    <= S_FIN;
            end else begin
              case (step)
                3'd0: raw_q.lim_lo   <= mem_rsp_data;
                3'd1: raw_q.base_lo  <= mem_rsp_data;
                3'd2: raw_q.base_mid <= mem_rsp_data[7:0];
                3'd3: raw_q.acc      <= mem_rsp_data[7:0];
                3'd4: raw_q.attr     <= mem_rsp_data[7:0];
                3'd5: raw_q.base_hi  <= mem_rsp_data[7:0];
                default: ;
              endcase
              if (last_step) begin
                state <= S_FIN;
              end else begin
                step  <= step + 3'd1;
                state <= S_ISSUE;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == S_ISSUE);
  assign mem_we        = (step == WRITE_STEP);
  assign mem_word      = (step < 3'd2);
  assign mem_addr      = dbase_q + ADDR_W'(step_offset(step));
  assign mem_wdata     = {8'h00, busy_byte};

  assign raw          = raw_q;
  assign is_task      = (op_q == OP_LOAD_TASK);
  assign load_sel     = sel_q;
  assign done         = (state == S_FIN);
  assign done_status  = status_q;
  assign result_sel   = result_q;
  assign commit_local = done && (status_q == ST_OK) && (op_q == OP_LOAD_LOCAL);
  assign commit_task  = done && (status_q == ST_OK) && (op_q == OP_LOAD_TASK);

  // R1: a refused load finishes at once without touching memory
  assert_priv_no_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op[1] && priv_bad) |=> (done && !mem_req_valid && !commit_local && !commit_task));

  // R7: read operations finish at once with no memory request
  assert_read_no_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !cmd_op[1]) |=> (done && !mem_req_valid));

  // R6: the only write is a byte write carrying the busy bit, for a task load
  assert_busy_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we) |-> (!mem_word && mem_wdata[1] && is_task));

  // R8: a faulted response never leads to a commit
  assert_fault_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && mem_rsp_valid && mem_rsp_fault) |=> (done && !commit_local && !commit_task));

  // R9: done lasts one cycle and the block is busy after acceptance
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_after_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_ready);

  // R11: a stalled request is held unchanged
  assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_word)));

endmodule

// File: rtl/seg_table_loader.sv
module seg_table_loader
  import dtr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [15:0]       cmd_sel,
  input  logic [1:0]        cur_cpl,
  input  logic              virt_mode,
  input  logic              prot_en,
  input  logic [ADDR_W-1:0] gtab_base,
  output logic              done,
  output logic [1:0]        done_status,
  output logic [15:0]       result_sel,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_fault,
  input  logic [15:0]       mem_rsp_data,
  output logic [15:0]       ldt_sel,
  output logic [31:0]       ldt_base,
  output logic [31:0]       ldt_limit,
  output logic [7:0]        ldt_access,
  output logic [15:0]       tr_sel,
  output logic [31:0]       tr_base,
  output logic [31:0]       tr_limit,
  output logic [7:0]        tr_access
);
  localparam int NUM_REGS = 2;   // index 0: local table, 1: task

  desc_raw_t        raw;
  logic             is_task;
  logic [SEL_W-1:0] load_sel;
  logic             commit_local;
  logic             commit_task;
  logic [REG_W-1:0] u_base;
  logic [REG_W-1:0] u_limit;
  logic [7:0]       u_access;
  logic [7:0]       u_busy;

  logic [NUM_REGS-1:0] commit;
  logic [SEL_W-1:0]    sh_sel    [NUM_REGS];
  logic [REG_W-1:0]    sh_base   [NUM_REGS];
  logic [REG_W-1:0]    sh_limit  [NUM_REGS];
  logic [7:0]          sh_access [NUM_REGS];

  stl_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_sel       (cmd_sel),
    .cur_cpl       (cur_cpl),
    .virt_mode     (virt_mode),
    .prot_en       (prot_en),
    .gtab_base     (gtab_base),
    .held_local_sel(sh_sel[0]),
    .held_task_sel (sh_sel[1]),
    .busy_byte     (u_busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_we        (mem_we),
    .mem_word      (mem_word),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_fault (mem_rsp_fault),
    .mem_rsp_data  (mem_rsp_data),
    .raw           (raw),
    .is_task       (is_task),
    .load_sel      (load_sel),
    .commit_local  (commit_local),
    .commit_task   (commit_task),
    .done          (done),
    .done_status   (done_status),
    .result_sel    (result_sel)
  );

  stl_unpack #(.PAGE_SHIFT(PAGE_SHIFT)) u_unpack (
    .raw      (raw),
    .is_task  (is_task),
    .base     (u_base),
    .limit    (u_limit),
    .access   (u_access),
    .busy_byte(u_busy)
  );

  assign commit = {commit_task, commit_local};

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_shadow
      stl_shadow u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit[g]),
        .sel_in   (load_sel),
        .base_in  (u_base),
        .limit_in (u_limit),
        .access_in(u_access),
        .sel_q    (sh_sel[g]),
        .base_q   (sh_base[g]),
        .limit_q  (sh_limit[g]),
        .access_q (sh_access[g])
      );
    end
  endgenerate

  assign ldt_sel    = sh_sel[0];
  assign ldt_base   = sh_base[0];
  assign ldt_limit  = sh_limit[0];
  assign ldt_access = sh_access[0];
  assign tr_sel     = sh_sel[1];
  assign tr_base    = sh_base[1];
  assign tr_limit   = sh_limit[1];
  assign tr_access  = sh_access[1];

  // R6: a committed task register always carries the busy bit
  assert_task_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_task |=> tr_access[1]);

  // R9: at most one register commits per command
  assert_single_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit));

endmodule

// File: tb/seg_table_loader_bench.sv
module seg_table_loader_bench;
  localparam logic [31:0] GB = 32'h0000_0040;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] sel;
    logic [1:0]  cpl;
    logic        vm;
    logic        pe;
    logic        fen;
    logic        fwe;
    logic [2:0]  foff;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
    '{2'd2, 16'h0010, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
    '{2'd2, 16'h001F, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
    '{2'd3, 16'h0028, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
    '{2'd1, 16'h0000, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    '{2'd0, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
    '{2'd2, 16'h0010, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
    '{2'd3, 16'h0030, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    '{2'd2, 16'h0033, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
    '{2'd2, 16'h0020, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd6},
    '{2'd3, 16'h0038, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd5},
    '{2'd3, 16'h003C, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
    '{2'd3, 16'h0040, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0},
    '{2'd1, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [15:0] cmd_sel = '0;
  logic [1:0]  cur_cpl = '0;
  logic        virt_mode = 1'b0;
  logic        prot_en = 1'b0;
  logic        done;
  logic [1:0]  done_status;
  logic [15:0] result_sel;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_we;
  logic        mem_word;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_rsp_valid;
  logic        mem_rsp_fault;
  logic [15:0] mem_rsp_data;
  logic [15:0] ldt_sel, tr_sel;
  logic [31:0] ldt_base, ldt_limit, tr_base, tr_limit;
  logic [7:0]  ldt_access, tr_access;

  seg_table_loader u_seg_table_loader (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cur_cpl(cur_cpl), .virt_mode(virt_mode),
    .prot_en(prot_en), .gtab_base(GB), .done(done), .done_status(done_status),
    .result_sel(result_sel), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_fault(mem_rsp_fault), .mem_rsp_data(mem_rsp_data),
    .ldt_sel(ldt_sel), .ldt_base(ldt_base), .ldt_limit(ldt_limit), .ldt_access(ldt_access),
    .tr_sel(tr_sel), .tr_base(tr_base), .tr_limit(tr_limit), .tr_access(tr_access)
  );

  // memory model with random stalls and fault injection
  logic [7:0] mem [256];
  logic [7:0] lfsr;
  logic       rdy_q;
  logic       flt_en = 1'b0;
  logic       flt_we = 1'b0;
  logic [7:0] flt_addr = '0;
  int         req_cnt = 0;
  int         stall_err = 0;
  logic       hit;
  logic [7:0] ma;
  logic       prev_stall;
  logic [31:0] prev_addr;
  logic       prev_we, prev_word;

  assign mem_req_ready = rdy_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 29 + 7);
      mem[8'h56] <= 8'h85;  mem[8'h5E] <= 8'h03;  mem[8'h6E] <= 8'h4A;
      mem[8'h76] <= 8'h8F;  mem[8'h7E] <= 8'h81;  mem[8'h6D] <= 8'h89;
      mem[8'h7D] <= 8'h91;
      lfsr <= 8'h5A; rdy_q <= 1'b0;
      mem_rsp_valid <= 1'b0; mem_rsp_fault <= 1'b0; mem_rsp_data <= '0;
      prev_stall <= 1'b0;
    end else begin
      lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy_q <= lfsr[0] | lfsr[3];
      mem_rsp_valid <= 1'b0;
      prev_stall <= mem_req_valid && !mem_req_ready;
      prev_addr  <= mem_addr; prev_we <= mem_we; prev_word <= mem_word;
      if (prev_stall && (!mem_req_valid || mem_addr != prev_addr ||
                         mem_we != prev_we || mem_word != prev_word))
        stall_err <= stall_err + 1;
      if (mem_req_valid && mem_req_ready) begin
        ma  = mem_addr[7:0];
        hit = flt_en && (ma == flt_addr) && (mem_we == flt_we);
        req_cnt <= req_cnt + 1;
        mem_rsp_valid <= 1'b1;
        mem_rsp_fault <= hit;
        mem_rsp_data  <= mem_word ? {mem[8'(ma + 8'd1)], mem[ma]} : {8'h00, mem[ma]};
        if (mem_we && !hit) mem[ma] <= mem_wdata[7:0];
      end
    end
  end

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected state of the two shadow registers: 0 local, 1 task
  logic [15:0] e_sel [2];
  logic [31:0] e_base [2];
  logic [31:0] e_lim [2];
  logic [7:0]  e_acc [2];

  task automatic check_shadows(input string tag);
    chk(tag, "ldt_sel",    32'(ldt_sel),    32'(e_sel[0]));
    chk(tag, "ldt_base",   ldt_base,        e_base[0]);
    chk(tag, "ldt_limit",  ldt_limit,       e_lim[0]);
    chk(tag, "ldt_access", 32'(ldt_access), 32'(e_acc[0]));
    chk(tag, "tr_sel",     32'(tr_sel),     32'(e_sel[1]));
    chk(tag, "tr_base",    tr_base,         e_base[1]);
    chk(tag, "tr_limit",   tr_limit,        e_lim[1]);
    chk(tag, "tr_access",  32'(tr_access),  32'(e_acc[1]));
  endtask

  task automatic run_vec(input vec_t v);
    logic [7:0]  a;
    logic [7:0]  b [8];
    logic        is_load, task_op, priv, flt;
    logic [1:0]  est;
    logic [15:0] eres;
    logic [31:0] lim, base;
    int          ereq, r0, n;
    logic [7:0]  st_cap;
    logic [15:0] res_cap;

    a = 8'(GB[7:0] + {v.sel[7:3], 3'b000});
    for (int k = 0; k < 8; k++) b[k] = mem[8'(a + 8'(k))];
    is_load = v.op[1];
    task_op = v.op[0];
    priv = v.pe && ((v.cpl != 2'd0) || v.vm);
    flt  = v.fen && (v.fwe ? (task_op && v.foff == 3'd5) : (v.foff != 3'd1 && v.foff != 3'd3));
    eres = '0; ereq = 0;
    lim  = {12'h000, b[6][3:0], b[1], b[0]};
    if (b[6][7]) lim = (lim << 12) | 32'hFFF;
    base = {b[7], b[4], b[3], b[2]};
    if (!is_load) begin
      est = 2'd0; eres = e_sel[task_op];
    end else if (priv) begin
      est = 2'd1;
    end else if (flt) begin
      est = 2'd2;
      ereq = v.fwe ? 7 : -1;
    end else begin
      est = 2'd0;
      ereq = task_op ? 7 : 6;
    end

    flt_en = v.fen; flt_we = v.fwe; flt_addr = 8'(a + 8'(v.foff));
    r0 = req_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = v.op; cmd_sel = v.sel;
    cur_cpl = v.cpl; virt_mode = v.vm; prot_en = v.pe;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9", "cmd_ready low while busy", 32'(cmd_ready), 32'd0);
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    st_cap = 8'(done_status); res_cap = result_sel;
    @(negedge clk);
    chk("R9", "done one cycle", 32'(done), 32'd0);
    chk(est == 2'd1 ? "R1" : (est == 2'd2 ? "R8" : "R9"), "status", 32'(st_cap), 32'(est));
    if (!is_load) chk("R7", "result_sel", 32'(res_cap), 32'(eres));
    if (ereq >= 0) chk(is_load ? "R1" : "R7", "memory requests", 32'(req_cnt - r0), 32'(ereq));
    if (is_load && !priv && !flt) begin
      e_sel[task_op]  = v.sel;
      e_base[task_op] = base;
      e_lim[task_op]  = lim;
      e_acc[task_op]  = task_op ? (b[5] | 8'h02) : b[5];
    end
    if (is_load && task_op && !priv)
      chk("R6", "busy byte in memory", 32'(mem[8'(a + 8'd5)]),
          32'(flt ? b[5] : (b[5] | 8'h02)));
    check_shadows(is_load ? (b[6][7] ? "R5" : "R4") : "R7");
    chk("R3", "limit field low word", 32'(ldt_limit[15:0] | 16'h0), 32'(e_lim[0][15:0]));
    flt_en = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      e_sel[k] = '0; e_base[k] = '0; e_lim[k] = '0; e_acc[k] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check_shadows("R10");
    chk("R10", "done after reset", 32'(done), 32'd0);
    chk("R10", "cmd_ready after reset", 32'(cmd_ready), 32'd1);
    // R2: descriptor at 0x58 reached from selector 0x1F
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // R2: selector low bits kept in the register but not used for the address
    chk("R2", "selector stored whole", 32'(ldt_sel), 32'h0033);
    // R5: granular descriptor at 0x50 scaled, non-granular at 0x58 not
    run_vec('{2'd2, 16'h0012, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0});
    chk("R5", "low limit bits filled", 32'(ldt_limit[11:0]), 32'hFFF);
    run_vec('{2'd2, 16'h0018, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0});
    chk("R5", "no scaling without flag", 32'(ldt_limit[31:20]), 32'h0);
    chk("R11", "stalled request changed", 32'(stall_err), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule